// File: doc/BRIEF.md
# Hibernate and Wakeup Power Sequencer

This block decides when the rest of a low-power domain has its supply enabled and when that domain is held in reset. It shares a simple register bus with a real-time clock core. Software puts the domain to sleep by writing the sleep command register, and the power-enable output then goes low. While the domain sleeps, the block watches an active-low wakeup pin and an alarm request from the clock core.

The pin is first passed through a synchronizer. It then has to stay low for a programmed minimum number of clock ticks before it counts as a wakeup, so short glitches are rejected. An alarm request wakes the domain at once. On a wakeup the block turns power back on and drives an active-low reset output for a separately programmed number of ticks. After that it returns to normal operation.

Both durations are held in registers where only a masked band of bits can be written, so each count has a coarse granularity of 32 ticks. One clock cycle is one tick.

Top module: `pwr_hib_seq`

## Requirements
- R1: After the synchronous reset, power-enable and the reset output are both high, and the filter and hold registers read back as zero.
- R2: A write to address 0x24 keeps only write-data bits 15:5 as the filter count. A read of 0x24 returns those bits in place with all other bits zero, and read data appears on the cycle after the read strobe.
- R3: A write to address 0x28 keeps only write-data bits 11:5 as the hold count, and a read returns them in place with all other bits zero.
- R4: A write to address 0x20 with data bit 0 set, made while the block is active, drives power-enable low from the next cycle. The reset output stays high.
- R5: A write to address 0x20 has no effect when data bit 0 is clear. It also has no effect while the reset hold is running.
- R6: The wakeup pin passes through two flops. With filter count F, the pin must be sampled low on F+1 consecutive clock edges after synchronization. Power-enable rises F+3 clock edges after the first edge that samples the pin low.
- R7: If the pin goes high before the filter count is reached, the count restarts from zero at the next low period.
- R8: With filter count 0, the first synchronized low sample wakes the block, which is three clock edges after the pin falls.
- R9: While asleep, an alarm request sampled high wakes the block on that clock edge. While active, an alarm request has no effect on either output.
- R10: After a wakeup, power-enable is high and the reset output is low for exactly M+1 cycles, where M is the hold count. The block then returns to the active state with the reset output high. With M = 0, reset is low for one cycle.
- R11: Power-enable is low only while asleep, the reset output is low only during the hold, and the two are never low together.
- R12: Pin-low time that accrues before the sleep command does not count toward the filter. With the pin held low throughout, wakeup comes F+1 edges after the edge that accepts the sleep command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (8) | Register byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered |
| wake_pin_n | input | 1 | Asynchronous active-low wakeup pin |
| alarm_wake | input | 1 | Alarm wake request from the clock core |
| pwr_en | output | 1 | Domain power enable, low while asleep |
| rst_out_n | output | 1 | Active-low domain reset, low during the hold |

## Verification
Directed cases drive the pin low from the moment of sleep with filter counts of 64 and 0. Each one measures the edge count to wakeup, and the result separates a correct synchronizer depth and compare point from an off-by-one. A low pulse that is too short, followed by a second low period, shows whether the count restarts or carries over. A pin held low from before the sleep command shows whether pre-sleep time is wrongly credited. Alarm requests given while asleep and while active, and sleep writes given with bit 0 clear or during the hold, show which state gates each input. A constrained random phase then mixes bus writes that carry junk in the masked bits with random pin activity and alarms. It checks both outputs every cycle against a bench model, and reads the registers back through their masks.

// File: rtl/pwr_hib_pkg.sv
package pwr_hib_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HIBER  = 2'd1,
    ST_HOLD   = 2'd2
  } pwr_state_e;

  localparam int DEF_AW        = 8;
  localparam int DEF_DW        = 32;
  localparam int DEF_HIB_ADDR  = 'h20;
  localparam int DEF_FILT_ADDR = 'h24;
  localparam int DEF_HOLD_ADDR = 'h28;
  localparam int DEF_FILT_LO   = 5;
  localparam int DEF_FILT_HI   = 15;
  localparam int DEF_HOLD_LO   = 5;
  localparam int DEF_HOLD_HI   = 11;
  localparam int DEF_SYNC      = 2;

endpackage

// File: rtl/pwr_hib_regs.sv
module pwr_hib_regs
  import pwr_hib_pkg::*;
#(
  parameter int AW        = DEF_AW,
  parameter int DW        = DEF_DW,
  parameter int HIB_ADDR  = DEF_HIB_ADDR,
  parameter int FILT_ADDR = DEF_FILT_ADDR,
  parameter int HOLD_ADDR = DEF_HOLD_ADDR,
  parameter int FILT_LO   = DEF_FILT_LO,
  parameter int FILT_HI   = DEF_FILT_HI,
  parameter int HOLD_LO   = DEF_HOLD_LO,
  parameter int HOLD_HI   = DEF_HOLD_HI
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [FILT_HI:0]   filt_limit,
  output logic [HOLD_HI:0]   hold_limit,
  output logic               hib_req
);

  localparam int FW = FILT_HI - FILT_LO + 1;
  localparam int HW = HOLD_HI - HOLD_LO + 1;
  localparam logic [AW-1:0] A_HIB  = AW'(HIB_ADDR);
  localparam logic [AW-1:0] A_FILT = AW'(FILT_ADDR);
  localparam logic [AW-1:0] A_HOLD = AW'(HOLD_ADDR);

  logic [FW-1:0] filt_q;
  logic [HW-1:0] hold_q;
  logic [DW-1:0] rd_next;
  logic          wr_filt, wr_hold;
  logic          unused_wdata;

  assign wr_filt = bus_wr && (bus_addr == A_FILT);
  assign wr_hold = bus_wr && (bus_addr == A_HOLD);
  // R4: sleep command decode, bit 0 of the write data
  assign hib_req = bus_wr && (bus_addr == A_HIB) && bus_wdata[0];

  // bits that no register keeps
  assign unused_wdata = ^{bus_wdata[DW-1:FILT_HI+1], bus_wdata[FILT_LO-1:1]};

  // R2 R3: only the masked band of each register is stored
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= '0;
      hold_q <= '0;
    end else begin
      if (wr_filt) filt_q <= bus_wdata[FILT_HI:FILT_LO];
      if (wr_hold) hold_q <= bus_wdata[HOLD_HI:HOLD_LO];
    end
  end

  assign filt_limit = {filt_q, {FILT_LO{1'b0}}};
  assign hold_limit = {hold_q, {HOLD_LO{1'b0}}};

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_FILT) rd_next[FILT_HI:0] = filt_limit;
    else if (bus_addr == A_HOLD) rd_next[HOLD_HI:0] = hold_limit;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
  import pwr_hib_pkg::*;
#(
  parameter int CW   = DEF_FILT_HI + 1,
  parameter int SYNC = DEF_SYNC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_n,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt_q;
  logic            pin_low;

  // R6: synchronizer chain, reset to the released level
  for (genvar i = 0; i < SYNC; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b1;
        else     sync_q[0] <= pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b1;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign pin_low = !sync_q[SYNC-1];

  // R7 R12: count restarts on any high sample and while not asleep
  always_ff @(posedge clk) begin
    if (rst || !en || !pin_low) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  // R6 R8: accept on the (limit+1)-th consecutive low sample
  assign hit = en && pin_low && (cnt_q == limit);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_hib_pkg::*;
#(
  parameter int HCW = DEF_HOLD_HI + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hib_req,
  input  logic           wake_hit,
  input  logic           alarm,
  input  logic [HCW-1:0] hold_limit,
  output logic           in_hiber,
  output logic           pwr_en,
  output logic           rst_out_n
);

  pwr_state_e     state_q, state_d;
  logic [HCW-1:0] hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (hib_req) state_d = ST_HIBER;              // R4 R5
      end
      ST_HIBER: begin
        if (alarm || wake_hit) begin                  // R6 R9
          state_d = ST_HOLD;
          hold_d  = '0;
        end
      end
      ST_HOLD: begin
        if (hold_q == hold_limit) state_d = ST_ACTIVE; // R10
        else                      hold_d  = hold_q + 1'b1;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      hold_q    <= '0;
      pwr_en    <= 1'b1;
      rst_out_n <= 1'b1;
    end else begin
      state_q   <= state_d;
      hold_q    <= hold_d;
      pwr_en    <= (state_d != ST_HIBER);             // R11
      rst_out_n <= (state_d != ST_HOLD);
    end
  end

  assign in_hiber = (state_q == ST_HIBER);

endmodule

// File: rtl/pwr_hib_seq.sv
module pwr_hib_seq
  import pwr_hib_pkg::*;
#(
  parameter int AW        = DEF_AW,
  parameter int DW        = DEF_DW,
  parameter int HIB_ADDR  = DEF_HIB_ADDR,
  parameter int FILT_ADDR = DEF_FILT_ADDR,
  parameter int HOLD_ADDR = DEF_HOLD_ADDR,
  parameter int FILT_LO   = DEF_FILT_LO,
  parameter int FILT_HI   = DEF_FILT_HI,
  parameter int HOLD_LO   = DEF_HOLD_LO,
  parameter int HOLD_HI   = DEF_HOLD_HI,
  parameter int SYNC      = DEF_SYNC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wake_pin_n,
  input  logic          alarm_wake,
  output logic          pwr_en,
  output logic          rst_out_n
);

  localparam int FCW = FILT_HI + 1;
  localparam int HCW = HOLD_HI + 1;

  logic [FCW-1:0] filt_limit;
  logic [HCW-1:0] hold_limit;
  logic           hib_req;
  logic           in_hiber;
  logic           wake_hit;

  pwr_hib_regs #(
    .AW(AW), .DW(DW),
    .HIB_ADDR(HIB_ADDR), .FILT_ADDR(FILT_ADDR), .HOLD_ADDR(HOLD_ADDR),
    .FILT_LO(FILT_LO), .FILT_HI(FILT_HI), .HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .filt_limit (filt_limit),
    .hold_limit (hold_limit),
    .hib_req    (hib_req)
  );

  pwr_wake_filter #(
    .CW(FCW), .SYNC(SYNC)
  ) u_filt (
    .clk   (clk),
    .rst   (rst),
    .pin_n (wake_pin_n),
    .en    (in_hiber),
    .limit (filt_limit),
    .hit   (wake_hit)
  );

  pwr_seq_fsm #(
    .HCW(HCW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hib_req    (hib_req),
    .wake_hit   (wake_hit),
    .alarm      (alarm_wake),
    .hold_limit (hold_limit),
    .in_hiber   (in_hiber),
    .pwr_en     (pwr_en),
    .rst_out_n  (rst_out_n)
  );

endmodule

// File: rtl/pwr_hib_seq_chk.sv
module pwr_hib_seq_chk
  import pwr_hib_pkg::*;
#(
  parameter int AW       = DEF_AW,
  parameter int DW       = DEF_DW,
  parameter int HIB_ADDR = DEF_HIB_ADDR,
  parameter int FILT_LO  = DEF_FILT_LO,
  parameter int FILT_HI  = DEF_FILT_HI
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          alarm_wake,
  input logic          pwr_en,
  input logic          rst_out_n
);

  logic sleep_cmd;
  assign sleep_cmd = bus_wr && (bus_addr == AW'(HIB_ADDR)) && bus_wdata[0];

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pwr_en && rst_out_n)); // R1

  AST_RDATA_MASK: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[FILT_LO-1:0] == '0) && (bus_rdata[DW-1:FILT_HI+1] == '0)); // R2

  AST_SLEEP_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(sleep_cmd)); // R4

  AST_ACTIVE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && rst_out_n && !sleep_cmd) |=> pwr_en); // R5

  AST_ALARM_WAKES: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && alarm_wake) |=> (pwr_en && !rst_out_n)); // R9

  AST_WAKE_INTO_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> !rst_out_n); // R10

  AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> pwr_en); // R10

  AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (pwr_en || rst_out_n)); // R11

endmodule

bind pwr_hib_seq pwr_hib_seq_chk #(
  .AW(AW), .DW(DW), .HIB_ADDR(HIB_ADDR), .FILT_LO(FILT_LO), .FILT_HI(FILT_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .alarm_wake (alarm_wake),
  .pwr_en     (pwr_en),
  .rst_out_n  (rst_out_n)
);

// File: tb/sim_pwr_hib_seq.sv
`timescale 1ns/1ps
module sim_pwr_hib_seq;

  localparam logic [7:0] A_HIB  = 8'h20;
  localparam logic [7:0] A_FILT = 8'h24;
  localparam logic [7:0] A_HOLD = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_pin_n = 1'b1;
  logic        alarm_wake = 1'b0;
  logic        pwr_en;
  logic        rst_out_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit lock_en = 1'b0;

  always #4 clk = ~clk;

  pwr_hib_seq u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_pin_n(wake_pin_n), .alarm_wake(alarm_wake),
    .pwr_en(pwr_en), .rst_out_n(rst_out_n)
  );

  function automatic logic [31:0] filt_mask(input logic [31:0] v);
    return v & 32'h0000_FFE0;
  endfunction

  function automatic logic [31:0] hold_mask(input logic [31:0] v);
    return v & 32'h0000_0FE0;
  endfunction

  // behavioural model built from the requirements: 0 awake, 1 asleep, 2 hold
  int          m_st = 0;
  logic        m_s1 = 1'b1, m_s2 = 1'b1;
  logic [31:0] m_filt = '0, m_hold = '0;
  int          m_cnt = 0, m_hc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_st <= 0; m_s1 <= 1'b1; m_s2 <= 1'b1;
      m_filt <= '0; m_hold <= '0; m_cnt <= 0; m_hc <= 0;
    end else begin
      m_s1 <= wake_pin_n;
      m_s2 <= m_s1;
      if (bus_wr && bus_addr == A_FILT) m_filt <= filt_mask(bus_wdata);
      if (bus_wr && bus_addr == A_HOLD) m_hold <= hold_mask(bus_wdata);
      if (m_st == 1 && !m_s2) m_cnt <= m_cnt + 1;
      else                    m_cnt <= 0;
      case (m_st)
        0: if (bus_wr && bus_addr == A_HIB && bus_wdata[0]) m_st <= 1;
        1: if (alarm_wake || (!m_s2 && m_cnt == int'(m_filt))) begin
             m_st <= 2; m_hc <= 0;
           end
        default: if (m_hc == int'(m_hold)) m_st <= 0;
                 else m_hc <= m_hc + 1;
      endcase
    end
  end

  // R11: every cycle both outputs follow the model state
  always @(negedge clk) begin
    if (lock_en && !rst && !done) begin
      checks++;
      if (pwr_en !== (m_st != 1) || rst_out_n !== (m_st != 2)) begin
        fails++;
        $display("FAIL R11 lockstep: pwr_en=%0b rst_out_n=%0b expected %0b %0b",
                 pwr_en, rst_out_n, (m_st != 1), (m_st != 2));
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic edges_to_wake(output int n);
    n = 0;
    while (!pwr_en && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (!rst_out_n && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    lock_en = 1'b1;

    // R1 reset state
    chk("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
    chk("R1 rst_out_n", {31'd0, rst_out_n}, 32'd1);
    rd(A_FILT, d); chk("R1 filt reg", d, 32'd0);
    rd(A_HOLD, d); chk("R1 hold reg", d, 32'd0);

    // R2 R3 masking
    wr(A_FILT, 32'hFFFF_FFFF); rd(A_FILT, d); chk("R2 filt mask", d, 32'h0000_FFE0);
    wr(A_HOLD, 32'hFFFF_FFFF); rd(A_HOLD, d); chk("R3 hold mask", d, 32'h0000_0FE0);
    rd(A_HIB, d); chk("R2 sleep reg reads zero", d, 32'd0);

    // R5 bit 0 clear does nothing
    wr(A_HIB, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    chk("R5 bit0 clear", {31'd0, pwr_en}, 32'd1);

    // R4 R6 R10: filter 64, hold 96
    wr(A_FILT, 32'h40); wr(A_HOLD, 32'h60);
    wr(A_HIB, 32'h1);
    chk("R4 asleep", {30'd0, pwr_en, rst_out_n}, 32'b01);
    wake_pin_n = 1'b0;
    edges_to_wake(n); chk("R6 edges to wake F=64", n, 67);
    hold_len(n); chk("R10 hold M=96", n, 97);
    wake_pin_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 short pulse restarts the count
    wr(A_HIB, 32'h1);
    wake_pin_n = 1'b0; repeat (30) @(negedge clk);
    chk("R7 no early wake", {31'd0, pwr_en}, 32'd0);
    wake_pin_n = 1'b1; repeat (5) @(negedge clk);
    wake_pin_n = 1'b0;
    edges_to_wake(n); chk("R7 restarted count", n, 67);
    wake_pin_n = 1'b1;
    hold_len(n);

    // R8 R10 zero filter, zero hold
    wr(A_FILT, 32'h1F); wr(A_HOLD, 32'hFFFF_F01F);
    repeat (3) @(negedge clk);
    wr(A_HIB, 32'h1);
    wake_pin_n = 1'b0;
    edges_to_wake(n); chk("R8 zero filter", n, 3);
    hold_len(n); chk("R10 zero hold", n, 1);
    wake_pin_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 alarm while active, then while asleep
    alarm_wake = 1'b1; repeat (5) @(negedge clk);
    chk("R9 alarm ignored when active", {30'd0, pwr_en, rst_out_n}, 32'b11);
    alarm_wake = 1'b0;
    wr(A_HOLD, 32'h100);
    wr(A_HIB, 32'h1);
    repeat (4) @(negedge clk);
    alarm_wake = 1'b1; @(negedge clk); alarm_wake = 1'b0;
    chk("R9 alarm wake", {30'd0, pwr_en, rst_out_n}, 32'b10);
    // R5 sleep command during hold is ignored
    wr(A_HIB, 32'h1);
    hold_len(n);
    repeat (3) @(negedge clk);
    chk("R5 ignored in hold", {30'd0, pwr_en, rst_out_n}, 32'b11);

    // R12 pre-sleep low time not credited
    wr(A_FILT, 32'h40); wr(A_HOLD, 32'h0);
    wake_pin_n = 1'b0; repeat (20) @(negedge clk);
    chk("R12 pin ignored when active", {30'd0, pwr_en, rst_out_n}, 32'b11);
    wr(A_HIB, 32'h1);
    edges_to_wake(n); chk("R12 count from sleep", n, 65);
    wake_pin_n = 1'b1;
    repeat (4) @(negedge clk);

    // random phase, outputs checked every cycle by the model
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if ($urandom_range(0, 3) == 0) wake_pin_n = ~wake_pin_n;
      alarm_wake = ($urandom_range(0, 15) == 0);
      case (op)
        0: wr(A_FILT, ($urandom & 32'hFFFF_007F));
        1: wr(A_HOLD, ($urandom & 32'hFFFF_F07F));
        2, 3: wr(A_HIB, $urandom);
        4: begin
             rd(A_FILT, d); chk("R2 random readback", d, m_filt);
           end
        5: begin
             rd(A_HOLD, d); chk("R3 random readback", d, m_hold);
           end
        default: @(negedge clk);
      endcase
    end
    alarm_wake = 1'b0;
    wake_pin_n = 1'b1;
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule